// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences an 8-bit successive-approximation converter from a fast reference clock. It divides the reference clock into a slow conversion clock. The divide ratio is set by a 2-bit select and can be 16, 32, 48 or 64. A conversion can be started by a rising edge on an external start pin or on a start bit from the mode register. Once started, the block counts a fixed startup interval. It then resolves the code one bit at a time, MSB first. For each bit it drives a trial code to the external DAC and reads back a single comparator bit.

When the conversion ends, the code is loaded into the result register in one step and a one-cycle done pulse is raised. The same code is then sent out MSB first on a serial data and clock pair. The block also decodes the analog input selection and the step size from a range flag and a 2-bit channel field. Those two outputs steer the external input switch.

Top module: `sar_conv_seq`

## Requirements
- R1: The divide select picks the conversion-clock period in reference cycles: select 0 gives 16, select 1 gives 32, select 2 gives 48 and select 3 gives 64. The select is captured when a conversion is accepted. `convClk` is high for the first half of each period, low for the second half, and stays low while idle.
- R2: A conversion is accepted only on a low-to-high transition of `startPin` or `startBit`. A source held high does not start another conversion. A source that is already high when reset is released does not start one.
- R3: `busy` stays high for exactly 14.5 conversion-clock periods (29 × select-dependent half-periods). `done` is high for exactly one cycle, the cycle after `busy` falls.
- R4: `trialCode` is 0x80 after a start. The first decision is made at the rising `convClk` edge that starts the seventh period, after six startup periods. At each of eight successive rising edges, bit 7 down to bit 0 in turn is kept when `cmpIn` is 1 and cleared when it is 0, and the next lower bit is set as the new trial.
- R5: Start edges that arrive while `busy` is high are ignored. This includes an edge in the final cycle of a conversion.
- R6: `result` keeps its previous value for the whole conversion. It changes only in the cycle in which `done` rises, and it then takes the final code.
- R7: After `done`, the result is shifted out MSB first on `serData`. Each bit spends one half-period with `serClk` low and one half-period with it high. Data changes only while `serClk` is low. Both outputs are 0 when no transfer is active.
- R8: `chanSel` is 1 for channel field 00 or 01, 2 for field 10 and 3 for field 11. This holds for either value of `rangeFlag`.
- R9: `stepMv` is 4 when flag 0 is combined with field 00 and 2 when flag 1 is combined with field 00. It is 8 for every other combination.
- R10: A synchronous active-high `rst` clears `result`, `trialCode`, `busy`, `done`, `serData` and `serClk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| divSel | input | 2 | Conversion-clock divide select |
| startPin | input | 1 | External start source, edge sensitive |
| startBit | input | 1 | Register start source, edge sensitive |
| cmpIn | input | 1 | Comparator decision for the current trial code |
| rangeFlag | input | 1 | Range mode flag |
| chanField | input | 2 | Channel/range field |
| trialCode | output | 8 | Code presented to the DAC |
| result | output | 8 | Last completed conversion result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| convClk | output | 1 | Divided conversion clock |
| serData | output | 1 | Serial result data |
| serClk | output | 1 | Serial result clock |
| chanSel | output | 2 | Selected analog input, 1 to 3 |
| stepMv | output | 4 | Step size in millivolts |

## Verification
Two events can fall on the same reference cycle: the final edge of a conversion, which loads the result and pulses done, and a new start edge. The bench provokes this by raising the idle source exactly one cycle before the final edge. Its behavioural model checks that `busy` drops, `done` pulses once and no new conversion begins. It also checks that a fresh edge on the next cycles is accepted while the serial shift of the previous result is still running, and that this shift continues undisturbed.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_W = 8;
  localparam int BIT_W = $clog2(RES_W);

  typedef struct packed {
    logic             start;
    logic             decide;
    logic [BIT_W-1:0] bitPos;
    logic             finish;
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int BASE_DIV = 16,
  parameter int STARTUP  = 6,
  localparam int MAX_HALF = BASE_DIV * 2,
  localparam int HL_W     = $clog2(MAX_HALF + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      divSel,
  input  logic            startPin,
  input  logic            startBit,
  output logic            busy,
  output logic            done,
  output logic            convClk,
  output logic [HL_W-1:0] hLen,
  output seqStrobe_t      stb
);
  localparam int NUM_HALF = 2 * STARTUP + 2 * RES_W + 1;
  localparam int HIDX_W   = $clog2(NUM_HALF);
  localparam int FIRST_DEC = 2 * STARTUP;
  localparam int LAST_DEC  = 2 * STARTUP + 2 * (RES_W - 1);

  logic [HL_W-1:0]   tick;
  logic [HIDX_W-1:0] halfIdx;
  logic              prevPin, prevBit, startReq, halfEnd;
  int                nextHalf;

  assign startReq = (startPin && !prevPin) || (startBit && !prevBit);
  assign halfEnd  = busy && (tick == hLen - HL_W'(1));
  assign convClk  = busy && !halfIdx[0];

  always_comb begin
    nextHalf   = int'(halfIdx) + 1;
    stb.start  = !busy && startReq;
    stb.finish = halfEnd && (int'(halfIdx) == NUM_HALF - 1);
    stb.decide = halfEnd && (nextHalf >= FIRST_DEC) && (nextHalf <= LAST_DEC)
                 && ((nextHalf % 2) == 0);
    stb.bitPos = BIT_W'(RES_W - 1 - (nextHalf - FIRST_DEC) / 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevPin <= 1'b1;
      prevBit <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      tick    <= '0;
      halfIdx <= '0;
      hLen    <= HL_W'(BASE_DIV / 2);
    end else begin
      prevPin <= startPin;
      prevBit <= startBit;
      done    <= stb.finish;
      if (stb.start) begin
        busy    <= 1'b1;
        tick    <= '0;
        halfIdx <= '0;
        hLen    <= HL_W'((BASE_DIV / 2) * (int'(divSel) + 1));
      end else if (busy) begin
        if (halfEnd) begin
          tick <= '0;
          if (stb.finish) begin
            busy    <= 1'b0;
            halfIdx <= '0;
          end else begin
            halfIdx <= halfIdx + HIDX_W'(1);
          end
        end else begin
          tick <= tick + HL_W'(1);
        end
      end
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy || $past(busy)));
  p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !stb.finish) |=> (busy && !done));
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int HL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       stb,
  input  logic [HL_W-1:0]  hLen,
  input  logic             cmpIn,
  input  logic             rangeFlag,
  input  logic [1:0]       chanField,
  output logic [RES_W-1:0] trialCode,
  output logic [RES_W-1:0] result,
  output logic             serData,
  output logic             serClk,
  output logic [1:0]       chanSel,
  output logic [3:0]       stepMv
);
  logic [RES_W-1:0] shReg;
  logic [HL_W-1:0]  shLen, shTick;
  logic [BIT_W-1:0] shBit;
  logic             shActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      trialCode <= '0;
      result    <= '0;
    end else if (stb.start) begin
      trialCode <= RES_W'(1) << (RES_W - 1);
    end else begin
      if (stb.decide) begin
        trialCode[stb.bitPos] <= cmpIn;
        if (stb.bitPos != '0) trialCode[stb.bitPos - BIT_W'(1)] <= 1'b1;
      end
      if (stb.finish) result <= trialCode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shActive <= 1'b0;
      shReg    <= '0;
      shLen    <= '0;
      shTick   <= '0;
      shBit    <= '0;
      serData  <= 1'b0;
      serClk   <= 1'b0;
    end else if (stb.finish) begin
      shActive <= 1'b1;
      shReg    <= trialCode;
      shLen    <= hLen;
      shTick   <= '0;
      shBit    <= '0;
      serData  <= trialCode[RES_W-1];
      serClk   <= 1'b0;
    end else if (shActive) begin
      if (shTick == shLen - HL_W'(1)) begin
        shTick <= '0;
        if (!serClk) begin
          serClk <= 1'b1;
        end else begin
          serClk <= 1'b0;
          if (shBit == BIT_W'(RES_W - 1)) begin
            shActive <= 1'b0;
            serData  <= 1'b0;
          end else begin
            shBit   <= shBit + BIT_W'(1);
            shReg   <= shReg << 1;
            serData <= shReg[RES_W-2];
          end
        end
      end else begin
        shTick <= shTick + HL_W'(1);
      end
    end
  end

  always_comb begin
    unique case (chanField)
      2'b10:   chanSel = 2'd2;
      2'b11:   chanSel = 2'd3;
      default: chanSel = 2'd1;
    endcase
    if (chanField == 2'b00) stepMv = rangeFlag ? 4'd2 : 4'd4;
    else                    stepMv = 4'd8;
  end

  p_data_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(serData) |-> !serClk);
  p_chan_valid_r8: assert property (@(posedge clk) disable iff (rst)
    chanSel != 2'd0);
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int BASE_DIV = 16,
  parameter int STARTUP  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       divSel,
  input  logic             startPin,
  input  logic             startBit,
  input  logic             cmpIn,
  input  logic             rangeFlag,
  input  logic [1:0]       chanField,
  output logic [RES_W-1:0] trialCode,
  output logic [RES_W-1:0] result,
  output logic             busy,
  output logic             done,
  output logic             convClk,
  output logic             serData,
  output logic             serClk,
  output logic [1:0]       chanSel,
  output logic [3:0]       stepMv
);
  localparam int HL_W = $clog2(BASE_DIV * 2 + 1);

  seqStrobe_t      stb;
  logic [HL_W-1:0] hLen;

  sar_seq_ctrl #(.BASE_DIV(BASE_DIV), .STARTUP(STARTUP)) u_ctrl (
    .clk(clk), .rst(rst), .divSel(divSel), .startPin(startPin),
    .startBit(startBit), .busy(busy), .done(done), .convClk(convClk),
    .hLen(hLen), .stb(stb)
  );

  sar_seq_dp #(.HL_W(HL_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .hLen(hLen), .cmpIn(cmpIn),
    .rangeFlag(rangeFlag), .chanField(chanField), .trialCode(trialCode),
    .result(result), .serData(serData), .serClk(serClk),
    .chanSel(chanSel), .stepMv(stepMv)
  );

  p_result_held_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(result));
  p_trial_start_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (trialCode == RES_W'(1) << (RES_W - 1)));
endmodule

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] divSel = 2'd0;
  logic       startPin = 1'b1;
  logic       startBit = 1'b0;
  logic       rangeFlag = 1'b0;
  logic [1:0] chanField = 2'd0;
  logic [7:0] vin = 8'd0;
  logic       cmpIn;
  logic [7:0] trialCode, result;
  logic       busy, done, convClk, serData, serClk;
  logic [1:0] chanSel;
  logic [3:0] stepMv;

  int vectors = 0;
  int fails = 0;
  bit started = 0;

  always #4 clk = ~clk;

  assign cmpIn = (trialCode <= vin);

  sar_conv_seq uut (
    .clk(clk), .rst(rst), .divSel(divSel), .startPin(startPin),
    .startBit(startBit), .cmpIn(cmpIn), .rangeFlag(rangeFlag),
    .chanField(chanField), .trialCode(trialCode), .result(result),
    .busy(busy), .done(done), .convClk(convClk), .serData(serData),
    .serClk(serClk), .chanSel(chanSel), .stepMv(stepMv)
  );

  // behavioural reference model: elapsed-time counters
  int   mH = 8, mT = 0, mS = 0;
  bit   mBusy = 0, mDone = 0, mShAct = 0, mPrevP = 1, mPrevB = 1;
  logic [7:0] mTrial = 0, mRes = 0, mSh = 0;

  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; mDone = 0; mShAct = 0; mPrevP = 1; mPrevB = 1;
      mTrial = 0; mRes = 0; mT = 0; mS = 0;
    end else begin
      bit edgeSeen;
      edgeSeen = (startPin && !mPrevP) || (startBit && !mPrevB);
      mPrevP = startPin; mPrevB = startBit;
      mDone = 0;
      if (mShAct) begin
        mS++;
        if (mS == 16 * mH) mShAct = 0;
      end
      if (mBusy) begin
        mT++;
        if (mT % mH == 0 && (mT / mH) >= 12 && (mT / mH) <= 26 && (mT / mH) % 2 == 0) begin
          int bp;
          bit keep;
          bp = 7 - ((mT / mH) - 12) / 2;
          keep = (mTrial <= vin);
          mTrial[bp] = keep;
          if (bp > 0) mTrial[bp-1] = 1'b1;
        end
        if (mT == 29 * mH) begin
          mBusy = 0; mDone = 1; mRes = mTrial; mSh = mTrial; mShAct = 1; mS = 0;
        end
      end else if (edgeSeen) begin
        mBusy = 1; mT = 0; mH = 8 * (int'(divSel) + 1); mTrial = 8'h80;
      end
    end
    started = 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      int eClk, eSd, eSc, eChan, eStep;
      #1;
      eClk = mBusy && ((mT / mH) % 2 == 0);
      eSc  = mShAct ? ((mS % (2 * mH)) >= mH) : 0;
      eSd  = mShAct ? mSh[7 - mS / (2 * mH)] : 0;
      eChan = (chanField == 2'b10) ? 2 : (chanField == 2'b11) ? 3 : 1;
      eStep = (chanField != 2'b00) ? 8 : (rangeFlag ? 2 : 4);
      chk("R1 convClk", convClk, eClk);
      chk("R2 R5 busy", busy, mBusy);
      chk("R3 done", done, mDone);
      chk("R4 trialCode", trialCode, mTrial);
      chk("R6 result", result, mRes);
      chk("R7 serClk", serClk, eSc);
      chk("R7 serData", serData, eSd);
      chk("R8 chanSel", chanSel, eChan);
      chk("R9 stepMv", stepMv, eStep);
      if (mDone) chk("R4 code equals input", result, vin);
    end
  end

  task automatic idleWait();
    do @(negedge clk); while (mBusy || mShAct);
  endtask

  task automatic runConv(input int dsel, input bit usePin, input logic [7:0] v,
                         input bit rangeF, input int field);
    @(negedge clk);
    divSel = 2'(dsel); vin = v; rangeFlag = rangeF; chanField = 2'(field);
    if (usePin) startPin = 1'b1; else startBit = 1'b1;
    @(negedge clk);
    repeat (40) @(negedge clk);
    // extra edge on the other source mid-conversion: must be ignored (R5)
    if (usePin) startBit = 1'b1; else startPin = 1'b1;
    repeat (3) @(negedge clk);
    if (usePin) startBit = 1'b0; else startPin = 1'b0;
    // edge landing on the final cycle of the conversion (R5)
    do @(negedge clk); while (!(mBusy && mT == 29 * mH - 1));
    if (usePin) startBit = 1'b1; else startPin = 1'b1;
    @(negedge clk);
    startPin = 1'b0; startBit = 1'b0;
    idleWait();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    chk("R10 reset result", result, 0);
    chk("R10 reset trial", trialCode, 0);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset serial", {serClk, serData}, 0);
    // source held high through reset must not start (R2)
    repeat (20) @(negedge clk);
    chk("R2 no start from held pin", busy, 0);
    startPin = 1'b0;
    @(negedge clk);
    runConv(0, 1, 8'hA5, 0, 0);
    runConv(1, 0, 8'h00, 1, 0);
    runConv(2, 1, 8'hFF, 0, 2);
    runConv(3, 0, 8'h5A, 1, 3);
    runConv(0, 0, 8'h7F, 1, 1);
    runConv(1, 1, 8'h80, 0, 3);
    // start during an active serial shift, both sources together
    @(negedge clk);
    vin = 8'h3C; divSel = 2'd0;
    startPin = 1'b1; startBit = 1'b1;
    do @(negedge clk); while (!mDone);
    startPin = 1'b0; startBit = 1'b0;
    repeat (30) @(negedge clk);
    vin = 8'hC3; startBit = 1'b1;
    @(negedge clk);
    startBit = 1'b0;
    idleWait();
    // reset in the middle of a conversion (R10)
    startPin = 1'b1;
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk("R10 mid reset busy", busy, 0);
    chk("R10 mid reset result", result, 0);
    repeat (10) @(negedge clk);
    startPin = 1'b0;
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule